// File: doc/BRIEF.md
# Activate window rate limiter

This block sits in the command path of a mobile DDR memory controller, in front of the stage that issues row ACTIVATE commands. It enforces two rules. The first is a pairwise rule: two activates must be at least a programmable number of clock cycles apart. The second is a rolling-window rule: at most four activates may fall inside one programmable window. A fifth activate waits until the window has elapsed, counted from the oldest of the four before it. The window rule applies only when the device is configured as an 8-bank part.

Requests arrive on a valid/ready handshake and carry a bank number. Each activate may target any bank. The limiter computes ready only from its own registered state. A request is accepted on the first cycle in which both rules are met. One cycle after acceptance, the limiter emits a grant pulse with the bank and the cycle stamp at which the activate was accepted. Cycles in which nothing is accepted correspond to NOP slots on the command bus.

The spacing, the window length and the bank mode sit in configuration registers. A load of these registers takes effect only in a cycle with no pending request.

Top module: `act_window_limiter`

## Requirements
- R1: After reset the history is empty and `req_ready` is 1, so the first request is accepted at once. The configuration resets to a spacing of 4 cycles, a window of 16 cycles and 8-bank mode.
- R2: Two accepted requests (`req_valid && req_ready` at a clock edge) are at least the configured spacing apart, counted in cycles.
- R3: In 8-bank mode, a request accepted at cycle t has t − t4 ≥ the configured window length, where t4 is the accept cycle of the fourth-most-recent earlier activate.
- R4: In 4-bank mode (`cfg_eight_in` loaded as 0), the window rule is not applied, and only the spacing rule limits the accept rate.
- R5: `req_ready` depends only on registered state and is 1 in exactly the cycles in which both rules allow an accept. A held request is therefore accepted on the first allowed cycle.
- R6: When `cfg_load` is 1 in a cycle with `req_valid` 0, the three configuration values are captured and govern from the next cycle. When `cfg_load` is 1 in a cycle with `req_valid` 1, the load is ignored.
- R7: One cycle after an accept, `act_valid` is 1 for one cycle. At that point `act_bank` holds the accepted bank and `act_stamp` holds the cycle count at the accept. The cycle count is 0 on the first edge after reset release and wraps modulo 2^TS_W.
- R8: A history entry older than 2^DLY_W cycles no longer holds back any request, so a stamp that has wrapped never causes a false hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Activate request pending |
| req_bank | input | BANK_W | Target bank of the request |
| req_ready | output | 1 | Request may be accepted in this cycle |
| cfg_load | input | 1 | Load the configuration values (honoured only when idle) |
| cfg_rrd_in | input | DLY_W | New minimum spacing between activates, in cycles |
| cfg_faw_in | input | DLY_W | New rolling window length, in cycles |
| cfg_eight_in | input | 1 | New bank mode: 1 = 8 banks (window rule on), 0 = 4 banks |
| act_valid | output | 1 | Grant pulse, one cycle after an accept |
| act_bank | output | BANK_W | Bank of the granted activate |
| act_stamp | output | TS_W | Cycle count at which the activate was accepted |

## Verification
The bench holds requests continuously so that every gap is set by the limiter alone. It then checks exact gaps: a window-bound fifth activate that is released one cycle late or early, or a window rule still applied in 4-bank mode, shows up as a wrong gap. A configuration load issued while a request is pending must leave the spacing unchanged; a design that honours it stretches the gaps. After an idle time chosen so that the wrapped stamp difference looks small, a request must be accepted at once; a design without history expiry holds it for nearly the whole spacing.

// File: rtl/act_lim_pkg.sv
package act_lim_pkg;
  localparam int WINDOW_ACTS = 4;
  localparam int PTR_W = $clog2(WINDOW_ACTS);

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(logic [PTR_W-1:0] p);
    return p - 1'b1;
  endfunction
endpackage

// File: rtl/act_lim_cfg.sv
module act_lim_cfg #(
  parameter int DLY_W     = 8,
  parameter int DEF_RRD   = 4,
  parameter int DEF_FAW   = 16,
  parameter int DEF_EIGHT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             load,
  input  logic [DLY_W-1:0] rrd_in,
  input  logic [DLY_W-1:0] faw_in,
  input  logic             eight_in,
  output logic [DLY_W-1:0] rrd_q,
  output logic [DLY_W-1:0] faw_q,
  output logic             eight_q
);
  wire take = load && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q   <= DLY_W'(DEF_RRD);
      faw_q   <= DLY_W'(DEF_FAW);
      eight_q <= (DEF_EIGHT != 0);
    end else if (take) begin
      rrd_q   <= rrd_in;
      faw_q   <= faw_in;
      eight_q <= eight_in;
    end
  end
endmodule

// File: rtl/act_lim_hist.sv
module act_lim_hist
  import act_lim_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int DLY_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic            push,
  output logic            last_vld,
  output logic [TS_W-1:0] last_age,
  output logic            full,
  output logic [TS_W-1:0] oldest_age
);
  logic [PTR_W-1:0]       wp;
  logic [WINDOW_ACTS-1:0] vld;
  logic [TS_W-1:0]        age [WINDOW_ACTS];
  logic [PTR_W-1:0]       lastp;

  function automatic logic [TS_W-1:0] age_of(logic [TS_W-1:0] n, logic [TS_W-1:0] t);
    return n - t;
  endfunction

  // an entry this old satisfies any programmable delay
  function automatic logic stale(logic [TS_W-1:0] a);
    return |(a >> DLY_W);
  endfunction

  for (genvar i = 0; i < WINDOW_ACTS; i++) begin : g_slot
    logic [TS_W-1:0] ts_q;
    logic            v_q;
    wire             hit = push && (wp == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        ts_q <= '0;
      end else if (hit) begin
        v_q  <= 1'b1;
        ts_q <= now;
      end else if (v_q && stale(age[i])) begin
        v_q  <= 1'b0;
      end
    end

    assign age[i] = age_of(now, ts_q);
    assign vld[i] = v_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    wp <= '0;
    else if (push) wp <= ptr_inc(wp);
  end

  assign lastp      = ptr_dec(wp);
  assign last_vld   = vld[lastp];
  assign last_age   = age[lastp];
  assign full       = &vld;
  assign oldest_age = age[wp];
endmodule

// File: rtl/act_lim_rules.sv
module act_lim_rules #(
  parameter int TS_W  = 16,
  parameter int DLY_W = 8
) (
  input  logic             last_vld,
  input  logic [TS_W-1:0]  last_age,
  input  logic             full,
  input  logic [TS_W-1:0]  oldest_age,
  input  logic [DLY_W-1:0] rrd,
  input  logic [DLY_W-1:0] faw,
  input  logic             eight,
  output logic             rrd_ok,
  output logic             faw_ok
);
  function automatic logic meets(logic [TS_W-1:0] a, logic [DLY_W-1:0] d);
    return a >= TS_W'(d);
  endfunction

  always_comb begin
    rrd_ok = !last_vld || meets(last_age, rrd);
    faw_ok = !eight || !full || meets(oldest_age, faw);
  end
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int TS_W      = 16,
  parameter int DLY_W     = 8,
  parameter int BANK_W    = 3,
  parameter int DEF_RRD   = 4,
  parameter int DEF_FAW   = 16,
  parameter int DEF_EIGHT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  output logic              req_ready,
  input  logic              cfg_load,
  input  logic [DLY_W-1:0]  cfg_rrd_in,
  input  logic [DLY_W-1:0]  cfg_faw_in,
  input  logic              cfg_eight_in,
  output logic              act_valid,
  output logic [BANK_W-1:0] act_bank,
  output logic [TS_W-1:0]   act_stamp
);
  logic [TS_W-1:0]  now;
  logic [DLY_W-1:0] cfg_rrd, cfg_faw;
  logic             cfg_eight;
  logic             last_vld, full;
  logic [TS_W-1:0]  last_age, oldest_age;
  logic             rrd_ok, faw_ok;
  logic             fire;

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  act_lim_cfg #(.DLY_W(DLY_W), .DEF_RRD(DEF_RRD), .DEF_FAW(DEF_FAW), .DEF_EIGHT(DEF_EIGHT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(req_valid), .load(cfg_load),
    .rrd_in(cfg_rrd_in), .faw_in(cfg_faw_in), .eight_in(cfg_eight_in),
    .rrd_q(cfg_rrd), .faw_q(cfg_faw), .eight_q(cfg_eight)
  );

  act_lim_hist #(.TS_W(TS_W), .DLY_W(DLY_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .now(now), .push(fire),
    .last_vld(last_vld), .last_age(last_age), .full(full), .oldest_age(oldest_age)
  );

  act_lim_rules #(.TS_W(TS_W), .DLY_W(DLY_W)) u_rules (
    .last_vld(last_vld), .last_age(last_age), .full(full), .oldest_age(oldest_age),
    .rrd(cfg_rrd), .faw(cfg_faw), .eight(cfg_eight),
    .rrd_ok(rrd_ok), .faw_ok(faw_ok)
  );

  assign req_ready = rrd_ok && faw_ok;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_bank  <= '0;
      act_stamp <= '0;
    end else begin
      act_valid <= fire;
      if (fire) begin
        act_bank  <= req_bank;
        act_stamp <= now;
      end
    end
  end
endmodule

// File: rtl/act_lim_chk.sv
module act_lim_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             act_valid,
  input logic [DLY_W-1:0] cfg_rrd,
  input logic [DLY_W-1:0] cfg_faw,
  input logic             cfg_eight
);
  localparam logic [DLY_W:0] SAT = {1'b1, {DLY_W{1'b0}}};
  wire fire = req_valid && req_ready;

  logic [DLY_W:0] since [4];
  logic [2:0]     cnt;

  function automatic logic [DLY_W:0] bump(logic [DLY_W:0] a);
    return (a == SAT) ? a : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < 4; k++) since[k] <= SAT;
    end else if (fire) begin
      if (cnt != 3'd4) cnt <= cnt + 1'b1;
      since[0] <= {{DLY_W{1'b0}}, 1'b1};
      for (int k = 1; k < 4; k++) since[k] <= bump(since[k-1]);
    end else begin
      for (int k = 0; k < 4; k++) since[k] <= bump(since[k]);
    end
  end

  assert_first_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 3'd0) |-> req_ready);
  assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt != 3'd0) |-> (since[0] >= {1'b0, cfg_rrd}));
  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_eight && cnt == 3'd4) |-> (since[3] >= {1'b0, cfg_faw}));
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($stable(cfg_rrd) && $stable(cfg_faw) && $stable(cfg_eight)));
  assert_grant_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> act_valid);
  assert_grant_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(fire));
endmodule

bind act_window_limiter act_lim_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .act_valid(act_valid), .cfg_rrd(cfg_rrd), .cfg_faw(cfg_faw), .cfg_eight(cfg_eight)
);

// File: tb/test_act_window_limiter.sv
module test_act_window_limiter;
  localparam int TS_W = 10, DLY_W = 8, BANK_W = 3;
  localparam int MASK = (1 << TS_W) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cfg_load = 0, cfg_eight_in = 0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [DLY_W-1:0]  cfg_rrd_in = '0, cfg_faw_in = '0;
  logic req_ready, act_valid;
  logic [BANK_W-1:0] act_bank;
  logic [TS_W-1:0]   act_stamp;

  act_window_limiter #(.TS_W(TS_W), .DLY_W(DLY_W), .BANK_W(BANK_W)) i_act_window_limiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank), .req_ready(req_ready),
    .cfg_load(cfg_load), .cfg_rrd_in(cfg_rrd_in), .cfg_faw_in(cfg_faw_in), .cfg_eight_in(cfg_eight_in),
    .act_valid(act_valid), .act_bank(act_bank), .act_stamp(act_stamp)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit running = 0, done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: true integer cycle numbers, no wrap
  int cyc = 0;
  int hq[$];
  int m_rrd = 4, m_faw = 16;
  bit m_eight = 1;
  bit exp_v = 0;
  int exp_bank = 0, exp_stamp = 0;

  always @(negedge clk) begin
    if (running) begin
      bit r;
      int n;
      n = hq.size();
      r = 1;
      if (n > 0 && cyc - hq[n-1] < m_rrd) r = 0;
      if (m_eight && n >= 4 && cyc - hq[n-4] < m_faw) r = 0;
      chk(req_ready == r, "R2 R3 R5 ready", int'(req_ready), int'(r));
      chk(act_valid == exp_v, "R7 grant pulse", int'(act_valid), int'(exp_v));
      if (exp_v) begin
        chk(int'(act_bank) == exp_bank, "R7 bank", int'(act_bank), exp_bank);
        chk(int'(act_stamp) == exp_stamp, "R7 stamp", int'(act_stamp), exp_stamp);
      end
      exp_v = req_valid && r;
      if (exp_v) begin
        exp_bank  = int'(req_bank);
        exp_stamp = cyc & MASK;
        hq.push_back(cyc);
        if (hq.size() > 4) void'(hq.pop_front());
      end
      if (cfg_load && !req_valid) begin
        m_rrd = int'(cfg_rrd_in); m_faw = int'(cfg_faw_in); m_eight = cfg_eight_in;
      end
      cyc++;
    end
  end

  int st_q[$];
  int iters;

  task automatic run_acts(int n, bit poke);
    int got = 0;
    st_q.delete();
    iters = 0;
    @(posedge clk); #1;
    req_valid = 1;
    if (poke) begin
      cfg_load = 1; cfg_rrd_in = 9; cfg_faw_in = 50; cfg_eight_in = 1;
    end
    while (got < n) begin
      @(posedge clk); #1;
      cfg_load = 0;
      iters++;
      if (act_valid) begin
        got++;
        st_q.push_back(int'(act_stamp));
        req_bank = req_bank + 1'b1;
      end
    end
    req_valid = 0;
  endtask

  task automatic set_cfg(int rrd, int faw, bit eight);
    @(posedge clk); #1;
    cfg_load = 1; cfg_rrd_in = DLY_W'(rrd); cfg_faw_in = DLY_W'(faw); cfg_eight_in = eight;
    @(posedge clk); #1;
    cfg_load = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int gap(int a, int b);
    return (b - a) & MASK;
  endfunction

  task automatic chk_gaps(string tag, int exp[]);
    foreach (exp[k]) chk(gap(st_q[k], st_q[k+1]) == exp[k], tag, gap(st_q[k], st_q[k+1]), exp[k]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(act_valid == 1'b0, "R1 no grant after reset", int'(act_valid), 0);

    // R1 defaults: spacing 4, window 16 not binding for the fifth
    run_acts(5, 0);
    chk(st_q[0] == 1, "R1 first accept at once", st_q[0], 1);
    chk_gaps("R1 default gaps", '{4, 4, 4, 4});

    // R3 window holds the fifth activate, R2 spacing otherwise
    idle(300);
    set_cfg(2, 20, 1);
    run_acts(6, 0);
    chk(iters == 1 + 2 + 2 + 2 + 14 + 2, "R5 held request released on first allowed cycle", iters, 23);
    chk_gaps("R2 R3 eight-bank gaps", '{2, 2, 2, 14, 2});

    // R4 four-bank mode ignores the window
    idle(300);
    set_cfg(2, 20, 0);
    run_acts(6, 0);
    chk_gaps("R4 four-bank gaps", '{2, 2, 2, 2, 2});

    // R6 load while request pending is ignored
    idle(300);
    run_acts(5, 1);
    chk_gaps("R6 busy load ignored", '{2, 2, 2, 2});
    idle(300);
    set_cfg(9, 50, 0);
    run_acts(2, 0);
    chk_gaps("R6 idle load taken", '{9});

    // R8 stale history expires before the stamp wraps
    idle(300);
    set_cfg(200, 255, 1);
    run_acts(1, 0);
    idle(1026);
    run_acts(1, 0);
    chk(iters == 1, "R8 accepted at once after long idle", iters, 1);

    idle(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule